// File: doc/BRIEF.md
# Gated Ring-Oscillator Edge Counter

This block measures how fast a free-running on-chip oscillator runs by counting its rising edges during a window timed in test-clock (TCK) periods. A short TCK-domain window counter is loaded with a start value and a run flag. It counts up to its all-ones terminal value and then raises a sticky stop flag. The oscillator-domain edge counter is enabled in phase with TCK when the window opens. The stop flag is carried into the oscillator domain through two flip-flops, so counting ends a fixed two oscillator edges after the window closes.

The synchronized stop is then carried back into the TCK domain to raise a done flag. Once done is high, the edge count is frozen and can be read safely. A shorter window is chosen by loading a larger start value. The edge counter saturates at its maximum and raises a sticky overflow flag. It is cleared only by reset, so a reset is applied before each fresh measurement. The oscillator is expected to run at more than twice the TCK frequency. All pins are plain control and status signals: there is no streaming interface and no back-pressure.

Top module: `ro_meter`

## Requirements
- R1: While reset is asserted and after it is released, stop, done and overflow are low and the edge count is zero.
- R2: On a TCK rising edge with load high, the window counter takes load_start. If load_en is high it advances on each following TCK edge, and stop goes high exactly 32 minus load_start TCK edges after the load edge (a start of 31 gives one edge).
- R3: Once high, stop stays high until reset or until the next load.
- R4: A load with load_en low opens no window: stop stays low and the edge count does not advance.
- R5: While a window is armed, the edge count rises by exactly one on every oscillator rising edge. This continues up to and including the second oscillator edge after stop rises, and after that the count holds.
- R6: done goes high on the second TCK rising edge after the edge that raised stop. It is never high while stop is low. While done is high the edge count does not change.
- R7: When an enabled oscillator edge arrives with the count at 1023 (all ones of the 10-bit counter), the count stays at 1023 and overflow goes high. Overflow stays high until reset.
- R8: A load during a running window aborts it. stop and done go low on the load edge, and the window restarts from the new start value with the R2 timing.
- R9: A load does not clear the edge count. A new window that follows a completed one without a reset adds to the previous count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock for the window and done logic |
| osc_clk | input | 1 | Oscillator clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| load | input | 1 | Load strobe for the start value, sampled on tck |
| load_start | input | 5 | Window start value; the window runs up to 31 |
| load_en | input | 1 | Run flag taken with the load |
| stop | output | 1 | Sticky window-closed flag |
| done | output | 1 | Count frozen and safe to read |
| edge_count | output | 10 | Accumulated oscillator edges |
| overflow | output | 1 | Sticky saturation flag |

## Verification
A wrong window count or terminal compare shows at the stop pin within one TCK period of the edge where stop was due, because the bench counts TCK edges from the load edge. A stop synchronizer with the wrong depth, or an enable that leaks, changes the edge count at the next oscillator edge. The mismatch then stands at the next TCK falling edge, where the behavioural model is compared. A missing saturation or a missing abort clear shows as a count or flag mismatch within one TCK period of the event.

// File: rtl/ro_meter_pkg.sv
package ro_meter_pkg;
  localparam int WIN_W_DEF   = 5;
  localparam int CNT_W_DEF   = 10;
  localparam int SYNC_N_DEF  = 2;
endpackage

// File: rtl/rom_window.sv
module rom_window #(
  parameter int WIN_W = 5
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIN_W-1:0] load_start,
  input  logic             load_en,
  output logic             armed,
  output logic             running,
  output logic             stop,
  output logic [WIN_W-1:0] win_cnt
);
  localparam logic [WIN_W-1:0] TERM = '1;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      running <= 1'b0;
      armed   <= 1'b0;
      stop    <= 1'b0;
    end else if (load) begin
      win_cnt <= load_start;
      running <= load_en;
      armed   <= load_en;
      stop    <= 1'b0;
    end else if (running) begin
      if (win_cnt == TERM) begin
        running <= 1'b0;
        stop    <= 1'b1;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rom_sync.sv
module rom_sync #(
  parameter int N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [N-1:0] chain;

  for (genvar i = 0; i < N; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   chain[i] <= 1'b0;
      else if (clr) chain[i] <= 1'b0;
      else          chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
    end
  end

  assign q = chain[N-1];
endmodule

// File: rtl/rom_edge_counter.sv
module rom_edge_counter #(
  parameter int CNT_W = 10
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (en) begin
      if (count == MAXV) overflow <= 1'b1;
      else               count    <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ro_meter.sv
module ro_meter
  import ro_meter_pkg::*;
#(
  parameter int WIN_W  = WIN_W_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  parameter int SYNC_N = SYNC_N_DEF
) (
  input  logic             tck,
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIN_W-1:0] load_start,
  input  logic             load_en,
  output logic             stop,
  output logic             done,
  output logic [CNT_W-1:0] edge_count,
  output logic             overflow
);
  logic             armed;
  logic             running;
  logic [WIN_W-1:0] win_cnt;
  logic             stop_osc;
  logic             stop_ack;
  logic             osc_en;

  rom_window #(.WIN_W(WIN_W)) u_window (
    .tck(tck), .rst_n(rst_n), .load(load), .load_start(load_start),
    .load_en(load_en), .armed(armed), .running(running), .stop(stop),
    .win_cnt(win_cnt)
  );

  rom_sync #(.N(SYNC_N)) u_stop_to_osc (
    .clk(osc_clk), .rst_n(rst_n), .clr(1'b0), .d(stop), .q(stop_osc)
  );

  assign osc_en = armed & ~stop_osc;

  rom_edge_counter #(.CNT_W(CNT_W)) u_edges (
    .osc_clk(osc_clk), .rst_n(rst_n), .en(osc_en),
    .count(edge_count), .overflow(overflow)
  );

  rom_sync #(.N(SYNC_N)) u_ack_to_tck (
    .clk(tck), .rst_n(rst_n), .clr(load), .d(stop_osc), .q(stop_ack)
  );

  assign done = stop & stop_ack;
endmodule

// File: rtl/ro_meter_checker.sv
module ro_meter_checker #(
  parameter int WIN_W = 5,
  parameter int CNT_W = 10
) (
  input logic             tck,
  input logic             osc_clk,
  input logic             rst_n,
  input logic             load,
  input logic             stop,
  input logic             done,
  input logic             running,
  input logic [WIN_W-1:0] win_cnt,
  input logic [CNT_W-1:0] edge_count,
  input logic             overflow
);
  localparam logic [WIN_W-1:0] TERM = '1;
  localparam logic [CNT_W-1:0] FULL = '1;

  assert_stop_sticky_R3: assert property (@(posedge tck) disable iff (!rst_n)
    stop && !load |=> stop);

  assert_load_clears_R8: assert property (@(posedge tck) disable iff (!rst_n)
    load |=> !stop && !done);

  assert_term_stop_R2: assert property (@(posedge tck) disable iff (!rst_n)
    running && (win_cnt == TERM) && !load |=> stop);

  assert_done_needs_stop_R6: assert property (@(posedge tck) disable iff (!rst_n)
    done |-> stop);

  assert_count_step_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    edge_count != $past(edge_count) |-> edge_count == $past(edge_count) + 1'b1);

  assert_hold_after_done_R6: assert property (@(posedge osc_clk) disable iff (!rst_n)
    done |=> $stable(edge_count));

  assert_ovf_sticky_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_ovf_full_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    overflow |-> edge_count == FULL);
endmodule

bind ro_meter ro_meter_checker #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_checker (
  .tck(tck), .osc_clk(osc_clk), .rst_n(rst_n), .load(load), .stop(stop),
  .done(done), .running(running), .win_cnt(win_cnt),
  .edge_count(edge_count), .overflow(overflow)
);

// File: tb/ro_meter_bench.sv
`timescale 1ns/1ps
module ro_meter_bench;
  logic       tck = 1'b0;
  logic       osc = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [4:0] load_start = '0;
  logic       load_en = 1'b0;
  logic       stop, done, overflow;
  logic [9:0] edge_count;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  ro_meter u_ro_meter (
    .tck(tck), .osc_clk(osc), .rst_n(rst_n), .load(load),
    .load_start(load_start), .load_en(load_en), .stop(stop), .done(done),
    .edge_count(edge_count), .overflow(overflow)
  );

  always #10 tck = ~tck;
  initial begin
    #0.103;
    forever #0.31 osc = ~osc;
  end

  // behavioural reference model
  int m_win, m_cnt;
  bit m_run, m_arm, m_stop, m_d1, m_d2, m_h1, m_h2, m_ovf;

  always @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      m_win = 0; m_run = 0; m_arm = 0; m_stop = 0; m_d1 = 0; m_d2 = 0;
    end else if (load) begin
      m_win = load_start; m_run = load_en; m_arm = load_en;
      m_stop = 0; m_d1 = 0; m_d2 = 0;
    end else begin
      m_d2 = m_d1;
      m_d1 = m_h2;
      if (m_run) begin
        if (m_win == 31) begin m_run = 0; m_stop = 1; end
        else m_win = m_win + 1;
      end
    end
  end

  always @(posedge osc or negedge rst_n) begin
    if (!rst_n) begin
      m_h1 = 0; m_h2 = 0; m_cnt = 0; m_ovf = 0;
    end else begin
      if (m_arm && !m_h2) begin
        if (m_cnt == 1023) m_ovf = 1;
        else m_cnt = m_cnt + 1;
      end
      m_h2 = m_h1;
      m_h1 = m_stop;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge tck) begin
    if (cmp_on && rst_n) begin
      check(stop == m_stop, "R2 stop vs model", stop, m_stop);
      check(done == (m_stop && m_d2), "R6 done vs model", done, m_stop && m_d2);
      check(edge_count == m_cnt, "R5 count vs model", edge_count, m_cnt);
      check(overflow == m_ovf, "R7 overflow vs model", overflow, m_ovf);
    end
  end

  task automatic do_reset();
    @(negedge tck);
    rst_n = 1'b0;
    load = 1'b0;
    repeat (2) @(negedge tck);
    check(!stop && !done && !overflow && edge_count == 0, "R1 state in reset",
          edge_count, 0);
    rst_n = 1'b1;
    @(negedge tck);
    check(!stop && !done && !overflow && edge_count == 0, "R1 state after reset",
          {stop, done, overflow}, 0);
  endtask

  task automatic pulse_load(input int s, input bit en);
    load_start = 5'(s);
    load_en = en;
    load = 1'b1;
    @(negedge tck);
    load = 1'b0;
  endtask

  // returns edges counted after the load edge until stop, then until done
  task automatic time_window(input int s, output int to_stop, output int to_done);
    int k;
    pulse_load(s, 1'b1);
    k = 0;
    while (!stop && k < 40) begin @(negedge tck); k++; end
    to_stop = k;
    k = 0;
    while (!done && k < 10) begin @(negedge tck); k++; end
    to_done = k;
  endtask

  initial begin
    int ts, td, c0, c1;
    fork
      begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    cmp_on = 1'b1;
    do_reset();

    // shortest window
    time_window(31, ts, td);
    check(ts == 1, "R2 stop edges for start 31", ts, 1);
    check(td == 2, "R6 done edges after stop", td, 2);
    c0 = edge_count;
    check(c0 > 30 && c0 < 40, "R5 count range for 1-cycle window", c0, 34);
    repeat (5) @(negedge tck);
    check(edge_count == c0 && stop, "R3 stop and count held", edge_count, c0);

    // R9: next window without reset adds to the count
    time_window(30, ts, td);
    check(ts == 2, "R2 stop edges for start 30", ts, 2);
    c1 = edge_count;
    check(c1 > c0 + 60, "R9 count accumulates", c1, c0 + 66);

    // R4: load with enable low
    do_reset();
    pulse_load(5, 1'b0);
    repeat (40) @(negedge tck);
    check(!stop && !done, "R4 no stop without enable", stop, 0);
    check(edge_count == 0, "R4 count idle without enable", edge_count, 0);

    // mid-length window
    do_reset();
    time_window(20, ts, td);
    check(ts == 12, "R2 stop edges for start 20", ts, 12);
    check(td == 2, "R6 done edges for start 20", td, 2);

    // R8: abort and restart
    do_reset();
    pulse_load(10, 1'b1);
    repeat (4) @(negedge tck);
    time_window(25, ts, td);
    check(ts == 7, "R8 restart timing start 25", ts, 7);
    check(td == 2, "R8 done after restart", td, 2);
    // abort a finished window: stop and done drop on the load edge
    pulse_load(28, 1'b1);
    check(!stop && !done, "R8 load clears stop and done", {stop, done}, 0);
    repeat (8) @(negedge tck);

    // R7: saturation with the longest window
    do_reset();
    time_window(0, ts, td);
    check(ts == 32, "R2 stop edges for start 0", ts, 32);
    check(edge_count == 10'h3ff, "R7 count saturates", edge_count, 1023);
    check(overflow, "R7 overflow raised", overflow, 1);
    pulse_load(31, 1'b1);
    repeat (6) @(negedge tck);
    check(overflow && edge_count == 10'h3ff, "R7 overflow sticky", overflow, 1);
    do_reset();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule